// File: doc/BRIEF.md
# Input Deglitch Filter Bank

This block conditions a bank of digital input lines before software samples them. Each line first passes through a two-stage synchronizer. It can then go through a stability filter. A filtered line changes its reported level only after the synchronized input has held the new level for a full programmable interval. An unfiltered line reports the synchronized input directly. All lines share one interval, counted in ticks of 200 ns. A prescaler derives these ticks from the system clock.

Software reaches the block through a plain byte-wide register port. Writes are accepted in every cycle in which `wr_en` is high. Reads are combinational from `rd_addr`. There is no valid/ready handshake, because the block never applies back-pressure and never holds a result that must wait to be consumed.

A new interval value sits in a staging register until a load command copies it into the active interval. A separate command clears all filter state at once. The register offsets are fixed:
- 0x00–0x02: level bytes, read.
- 0x07: command.
- 0x08–0x0A: staged interval, write.
- 0x0C–0x0E: enable mask, write.

Top module: `dglitch_bank`

## Requirements
- R1: After reset, every enable bit is 0 and the active interval is 0. The level bytes therefore show the raw inputs, delayed by the synchronizer.
- R2: A channel with filtering off shows a new input level on the third rising clock edge after the input changes.
- R3: On a filtered channel with active interval N, a pulse on the synchronized input that lasts at most (N-1)·D clock cycles never reaches the reported level. D is the number of clock cycles per 200 ns tick.
- R4: On a filtered channel, a level that is held steady is reported no earlier than edge (N-1)·D+3 after the input change. It is reported no later than edge N·D+2.
- R5: Writes to the staged interval have no effect on filtering until a command write with bit 0 set. The staged interval occupies 0x08 (bits 7:0), 0x09 (bits 15:8) and the low 4 bits of 0x0A (bits 19:16).
- R6: A command write with bit 1 set takes effect on the second rising edge after the write is captured. At that edge, every channel's reported level is loaded with its synchronized input and every stability counter is cleared.
- R7: The enable mask is written at 0x0C, 0x0D and 0x0E. Bit k of the byte at 0x0C+j enables filtering for channel 8·j+k, and only for that channel.
- R8: An enabled channel passes its input unfiltered, with the R2 latency, while the active interval is 0.
- R9: Reading offset j (0 to 2) returns channels 8·j+7 down to 8·j, with channel 8·j in bit 0. Every other read offset returns 0.
- R10: The prescaler issues a one-cycle tick once every D clock cycles, and filtered outputs change only on tick cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 24 | Raw asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write offset |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 5 | Register read offset |
| rd_data | output | 8 | Register read byte (combinational) |

## Verification
An unfiltered channel is due on the third edge after its input changes. The bench samples it one cycle early, to confirm it has not moved yet, and then on time. A filtered channel is checked at edge (N-1)·D+2, where it must still hold the old level, and again at edge N·D+2, where it must hold the new one. This bracket holds whatever phase the prescaler is in. The load and clear commands are checked a fixed number of edges after the write is captured: one edge for the strobe register, plus the edge that acts on it. Glitches are held for exactly (N-1)·D cycles, and the output is sampled in every cycle until the filter window has passed.

// File: rtl/dglf_pkg.sv
package dglf_pkg;
  localparam int ADDR_W   = 5;
  localparam int A_LVL    = 0;
  localparam int A_CMD    = 7;
  localparam int A_IVL    = 8;
  localparam int A_EN     = 12;
  localparam int CMD_LOAD = 0;
  localparam int CMD_CLR  = 1;
endpackage

// File: rtl/dglf_tick.sv
module dglf_tick #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (cnt == CW'(DIV - 1))   cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(DIV - 1));

  // R10: ticks are single-cycle pulses when the divide exceeds one
  a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && DIV > 1) |=> !tick);
endmodule

// File: rtl/dglf_regs.sv
module dglf_regs
  import dglf_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int IVL_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] en_mask,
  output logic [IVL_W-1:0]  ivl_act,
  output logic              clr_q
);
  logic [IVL_W-1:0] ivl_stage;
  logic             load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_stage <= '0;
      ivl_act   <= '0;
      en_mask   <= '0;
      load_q    <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      load_q <= 1'b0;
      clr_q  <= 1'b0;
      if (wr_en) begin
        for (int i = 0; i < IVL_W; i++)
          if (wr_addr == ADDR_W'(A_IVL + i / 8)) ivl_stage[i] <= wr_data[i % 8];
        for (int i = 0; i < NUM_CH; i++)
          if (wr_addr == ADDR_W'(A_EN + i / 8)) en_mask[i] <= wr_data[i % 8];
        if (wr_addr == ADDR_W'(A_CMD)) begin
          load_q <= wr_data[CMD_LOAD];
          clr_q  <= wr_data[CMD_CLR];
        end
      end
      if (load_q) ivl_act <= ivl_stage;
    end
  end

  // R5: the active interval only moves in the cycle after a load command
  a_r5_hold_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |=> $stable(ivl_act));
endmodule

// File: rtl/dglf_chan.sv
module dglf_chan #(
  parameter int IVL_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             filt_on,
  input  logic [IVL_W-1:0] ivl,
  input  logic             din,
  output logic             dout
);
  logic             s1, s2;
  logic [IVL_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      dout <= 1'b0;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (clr || !filt_on) begin
        dout <= s2;
        cnt  <= '0;
      end else if (s2 == dout) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt >= ivl - 1'b1) begin
          dout <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R6: a clear loads the synchronized level
  a_r6_clear_loads: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> dout == $past(s2));
  // R10: a filtered output only moves on a tick
  a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && !clr && !tick) |=> $stable(dout));
  // R2: a bypassed channel follows the synchronizer
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_on) |=> dout == $past(s2));
endmodule

// File: rtl/dglitch_bank.sv
module dglitch_bank
  import dglf_pkg::*;
#(
  parameter int NUM_CH  = 24,
  parameter int IVL_W   = 20,
  parameter int CLK_MHZ = 100,
  parameter int TICK_NS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] din,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DIV      = (CLK_MHZ * TICK_NS) / 1000;
  localparam int CH_BYTES = (NUM_CH + 7) / 8;

  logic                tick, clr_q, ivl_nz;
  logic [NUM_CH-1:0]   en_mask, lvl;
  logic [IVL_W-1:0]    ivl_act;
  logic [CH_BYTES*8-1:0] lvl_pad;

  dglf_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  dglf_regs #(.NUM_CH(NUM_CH), .IVL_W(IVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_mask(en_mask), .ivl_act(ivl_act), .clr_q(clr_q));

  assign ivl_nz = (ivl_act != '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dglf_chan #(.IVL_W(IVL_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_q),
      .filt_on(en_mask[g] && ivl_nz), .ivl(ivl_act),
      .din(din[g]), .dout(lvl[g]));
  end

  assign lvl_pad = (CH_BYTES*8)'(lvl);

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < CH_BYTES; b++)
      if (rd_addr == ADDR_W'(A_LVL + b)) rd_data = lvl_pad[b*8 +: 8];
  end
endmodule

// File: tb/dglitch_bank_bench.sv
module dglitch_bank_bench;
  localparam int D = 20;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [23:0] din = '0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0, rd_data;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  dglitch_bank u_dglitch_bank (.clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_all(output logic [23:0] v);
    for (int b = 0; b < 3; b++) begin
      rd_addr = 5'(b); #1; v[b*8 +: 8] = rd_data;
    end
  endtask

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic set_ivl(input int n, input bit load);
    wr(8, n & 8'hff); wr(9, (n >> 8) & 8'hff); wr(10, (n >> 16) & 8'h0f);
    if (load) begin wr(7, 1); step(1); end
  endtask

  task automatic set_en(input logic [23:0] m);
    wr(12, m[7:0]); wr(13, m[15:8]); wr(14, m[23:16]);
  endtask

  // expected level: masked (filtered) bits keep old, others take new
  function automatic logic [23:0] mix(input logic [23:0] o, input logic [23:0] n,
                                      input logic [23:0] m);
    return (n & ~m) | (o & m);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [23:0] v, old, nw, m;
    int n;
    void'($urandom(32'd1234));
    step(3); rst_n = 1; step(1);
    rd_all(v); chk("R1 reset levels", v, 24'h0);

    // R2 exact latency, complement pattern
    din = 24'hffffff; step(2); rd_all(v); chk("R2 not before edge 3", v, 24'h0);
    step(1); rd_all(v); chk("R2 at edge 3", v, 24'hffffff);
    // R1/R2 random patterns, nothing enabled
    for (int i = 0; i < 10; i++) begin
      din = 24'($urandom); step(3); rd_all(v); chk("R1 R2 unfiltered follow", v, din);
    end

    // R9 other offsets read 0
    rd_addr = 5'd3; #1; chk("R9 offset 3 reads 0", {16'h0, rd_data}, 24'h0);
    rd_addr = 5'd20; #1; chk("R9 offset 20 reads 0", {16'h0, rd_data}, 24'h0);

    // R8 enabled with interval 0 passes through
    din = 24'h0; step(3);
    set_en(24'hffffff);
    din = 24'h5a5a5a; step(3); rd_all(v); chk("R8 zero interval bypass", v, 24'h5a5a5a);
    set_en(24'h0);
    din = 24'h0; step(3);

    // R7 only low byte filtered, interval 5
    n = 5; set_ivl(n, 1); set_en(24'h0000ff);
    din = 24'hffffff; step(3); rd_all(v); chk("R7 low byte filtered only", v, 24'hffff00);
    step((n-1)*D + 2 - 3); rd_all(v); chk("R4 lower bound", v, 24'hffff00);
    step(D); rd_all(v); chk("R4 R10 upper bound", v, 24'hffffff);

    // R3 glitch of (N-1)*D cycles is blocked
    din = 24'hffff00; step((n-1)*D); din = 24'hffffff;
    begin
      bit bad = 0;
      for (int c = 0; c < (n+2)*D; c++) begin
        step(1); rd_all(v);
        if (v[7:0] !== 8'hff) bad = 1;
      end
      chk("R3 glitch blocked", {23'h0, bad}, 24'h0);
    end

    // R5 staged interval without load keeps old interval
    set_ivl(2, 0);
    din = 24'hffff00; step((n-1)*D + 2); rd_all(v); chk("R5 unloaded keeps old", v, 24'hffffff);
    step(D); rd_all(v); chk("R5 old interval completes", v, 24'hffff00);
    wr(7, 1); step(1);
    din = 24'hffffff; step((2-1)*D + 2); rd_all(v); chk("R5 loaded lower bound", v, 24'hffff00);
    step(D); rd_all(v); chk("R5 loaded new interval", v, 24'hffffff);

    // R6 clear with long interval
    set_ivl(1000, 1); set_en(24'hffffff);
    din = 24'h123456; step(3); rd_all(v); chk("R6 held before clear", v, 24'hffffff);
    wr(7, 2); rd_all(v); chk("R6 not at capture edge", v, 24'hffffff);
    step(1); rd_all(v); chk("R6 clear loads input", v, 24'h123456);
    step(5); rd_all(v); chk("R6 stays after clear", v, 24'h123456);

    // random filtered rounds
    old = 24'h123456;
    for (int r = 0; r < 8; r++) begin
      n = 2 + int'($urandom % 5);
      m = 24'($urandom);
      set_ivl(n, 1); set_en(m);
      nw = old ^ 24'($urandom);
      din = nw; step(3); rd_all(v); chk("R2 R7 random bypass part", v, mix(old, nw, m));
      step((n-1)*D - 1); rd_all(v); chk("R4 random lower bound", v, mix(old, nw, m));
      step(D); rd_all(v); chk("R4 random upper bound", v, nw);
      old = nw;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule